// File: doc/BRIEF.md
# Write-Masked Pin Configuration Register File

This block holds the per-pin function-select and pull settings for a set of pin banks. Software reaches it through a simple 32-bit register port. Every register word has two halves. The low 16 bits carry data. The high 16 bits are per-bit write enables. An agent can therefore change one pin's field without reading the word first, and two agents that share a word cannot undo each other's changes.

Each bank has 32 pins. The mux area gives every pin a 2-bit function select: eight pins per word, four words per bank, and banks placed 0x10 bytes apart. The pull area gives every pin one pull-disable bit: sixteen pins per word, two words per bank, and a bank spacing that is a parameter of 8 or 16 bytes. The bank count and the base offsets of both areas are also parameters. The per-pin settings leave the block as two flat vectors, which feed the pad ring and the function multiplexers.

Top module: `pin_cfg_regs`

## Requirements
- R1: A write to a mapped word updates data bit n only when wdata bit n+16 is 1, for n = 0..15. Data bits whose enable bit is 0 keep their old value.
- R2: The function select of pin p in bank b lives in the word at MUX_BASE + b*0x10 + (p/8)*4, in bits (p%8)*2+1:(p%8)*2. It drives func_sel_o[(b*32+p)*2 +: 2].
- R3: Function select value 0 means the pin is routed to the GPIO block. After reset every function select is 0.
- R4: The pull bit of pin p in bank b lives in the word at PULL_BASE + b*PULL_STRIDE + (p/16)*4, in bit p%16. It drives pull_dis_o[b*32+p].
- R5: A pull bit of 0 keeps the pad's default pull enabled. A pull bit of 1 disables pulling. After reset every pull bit is 0.
- R6: A read request (req_i=1, we_i=0) returns the stored 16 data bits in rdata_o[15:0] and zeros in rdata_o[31:16]. The value appears after the clock edge that samples the request. In every other cycle rdata_o is zero.
- R7: An access to an unmapped offset changes nothing, and a read of it returns zero. Unmapped offsets include offsets that are not word aligned, offsets outside both areas, and the unused slots 0x8 and 0xC of a bank when PULL_STRIDE is 16.
- R8: The per-pin outputs take a written value on the clock edge that accepts the write. They do not change in any cycle without a write.
- R9: PULL_STRIDE selects a pull bank spacing of 8 or 16 bytes. The same offset therefore maps to different pull words, or to none, depending on this parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | High half = write enables, low half = data |
| rdata_o | output | 32 | Read data, registered |
| func_sel_o | output | NUM_BANKS*64 | Function select of each pin, 2 bits per pin |
| pull_dis_o | output | NUM_BANKS*32 | Pull-disable bit of each pin |

## Verification
A wrong write mask, or a decode that hits the wrong word, corrupts pins that the write never targeted. This shows at func_sel_o and pull_dis_o one edge after the write, and it stays there until that word is written again. The bench therefore compares every pin of both instances after each write, not just the targeted field. A stride-dependent decode fault shows as a difference between the stride-8 and stride-16 instances, which the bench drives with the same bus traffic. Read-path faults show in rdata_o one cycle after the request.

// File: rtl/pin_cfg_pkg.sv
package pin_cfg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  // keep bits whose enable is low, load bits whose enable is high
  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] wr
  );
    return (cur & ~wr[WORD_W-1:HALF_W]) | (wr[HALF_W-1:0] & wr[WORD_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/pin_cfg_decode.sv
module pin_cfg_decode #(
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned NUM_BANKS      = 4,
  parameter int unsigned MUX_BASE       = 'h0a8,
  parameter int unsigned PULL_BASE      = 'h118,
  parameter int unsigned PULL_STRIDE    = 8,
  parameter int unsigned MUX_PER_BANK   = 4,
  parameter int unsigned PULL_PER_BANK  = 2,
  parameter int unsigned MUX_STRIDE     = 'h10,
  localparam int unsigned NUM_MUX       = NUM_BANKS * MUX_PER_BANK,
  localparam int unsigned NUM_PULL      = NUM_BANKS * PULL_PER_BANK
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_MUX-1:0]  mux_sel_o,
  output logic [NUM_PULL-1:0] pull_sel_o
);
  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    localparam int unsigned OFS = MUX_BASE + (m / MUX_PER_BANK) * MUX_STRIDE
                                  + (m % MUX_PER_BANK) * 4;
    assign mux_sel_o[m] = (addr_i == ADDR_W'(OFS));
  end

  for (genvar p = 0; p < NUM_PULL; p++) begin : g_pull
    localparam int unsigned OFS = PULL_BASE + (p / PULL_PER_BANK) * PULL_STRIDE
                                  + (p % PULL_PER_BANK) * 4;
    assign pull_sel_o[p] = (addr_i == ADDR_W'(OFS));
  end
endmodule

// File: rtl/pin_cfg_word.sv
module pin_cfg_word
  import pin_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [HALF_W-1:0] q_o
);
  logic [HALF_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (wr_i) q_q <= masked_merge(q_q, wdata_i);
  end

  assign q_o = q_q;

  a_r1_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & ~$past(wdata_i[WORD_W-1:HALF_W])) ==
              ($past(q_o) & ~$past(wdata_i[WORD_W-1:HALF_W]))));

  a_r1_enabled_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & $past(wdata_i[WORD_W-1:HALF_W])) ==
              ($past(wdata_i[HALF_W-1:0]) & $past(wdata_i[WORD_W-1:HALF_W]))));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pin_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned MUX_BASE      = 'h0a8,
  parameter int unsigned PULL_BASE     = 'h118,
  parameter int unsigned PULL_STRIDE   = 8,
  localparam int unsigned PINS_PER_BANK = 32,
  localparam int unsigned MUX_PER_BANK  = PINS_PER_BANK / 8,
  localparam int unsigned PULL_PER_BANK = PINS_PER_BANK / 16,
  localparam int unsigned NUM_MUX       = NUM_BANKS * MUX_PER_BANK,
  localparam int unsigned NUM_PULL      = NUM_BANKS * PULL_PER_BANK,
  localparam int unsigned NUM_PINS      = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic [2*NUM_PINS-1:0] func_sel_o,
  output logic [NUM_PINS-1:0]   pull_dis_o
);
  logic [NUM_MUX-1:0]  mux_sel;
  logic [NUM_PULL-1:0] pull_sel;
  logic [HALF_W-1:0]   mux_q  [NUM_MUX];
  logic [HALF_W-1:0]   pull_q [NUM_PULL];
  logic [HALF_W-1:0]   rd_word;
  logic [WORD_W-1:0]   rdata_q;
  logic                wr_acc, rd_acc;

  assign wr_acc = req_i &  we_i;
  assign rd_acc = req_i & ~we_i;

  pin_cfg_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MUX_BASE(MUX_BASE),
    .PULL_BASE(PULL_BASE), .PULL_STRIDE(PULL_STRIDE),
    .MUX_PER_BANK(MUX_PER_BANK), .PULL_PER_BANK(PULL_PER_BANK), .MUX_STRIDE('h10)
  ) u_decode (
    .addr_i    (addr_i),
    .mux_sel_o (mux_sel),
    .pull_sel_o(pull_sel)
  );

  // mux words are laid out so word m feeds pins m*8 .. m*8+7 contiguously
  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    pin_cfg_word u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_acc & mux_sel[m]),
      .wdata_i(wdata_i),
      .q_o    (mux_q[m])
    );
    assign func_sel_o[m*HALF_W +: HALF_W] = mux_q[m];
  end

  for (genvar p = 0; p < NUM_PULL; p++) begin : g_pull
    pin_cfg_word u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_acc & pull_sel[p]),
      .wdata_i(wdata_i),
      .q_o    (pull_q[p])
    );
    assign pull_dis_o[p*HALF_W +: HALF_W] = pull_q[p];
  end

  always_comb begin
    rd_word = '0;
    for (int m = 0; m < NUM_MUX; m++)  if (mux_sel[m])  rd_word |= mux_q[m];
    for (int p = 0; p < NUM_PULL; p++) if (pull_sel[p]) rd_word |= pull_q[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_acc) rdata_q <= {{HALF_W{1'b0}}, rd_word};
    else             rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  a_r7_decode_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mux_sel, pull_sel}));

  a_r7_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !(|{mux_sel, pull_sel})) |=> (rdata_o == '0));

  a_r6_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> (rdata_o == '0));

  a_r8_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_acc |=> ($stable(func_sel_o) && $stable(pull_dis_o)));
endmodule

// File: tb/pin_cfg_regs_bench.sv
module pin_cfg_regs_bench;
  localparam int NB = 4;
  localparam int MB = 'h0a8;
  localparam int PB = 'h118;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd8, rd16;
  logic [2*NB*32-1:0] fs8, fs16;
  logic [NB*32-1:0]   pd8, pd16;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_mux [NB*4];
  logic [15:0] m_p8  [NB*2];
  logic [15:0] m_p16 [NB*2];

  logic [31:0] q_exp8[$], q_exp16[$];
  string       q_tag[$];
  logic        rd_pend = 1'b0;

  always #4 clk = ~clk;

  pin_cfg_regs #(.PULL_STRIDE(8)) u_pin_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd8), .func_sel_o(fs8), .pull_dis_o(pd8));

  pin_cfg_regs #(.PULL_STRIDE(16)) u_pin_cfg_regs_s16 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd16), .func_sel_o(fs16), .pull_dis_o(pd16));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mux_idx(int a);
    if (a % 4 != 0 || a < MB || a >= MB + NB*16) return -1;
    return (a - MB) / 4;
  endfunction

  function automatic int pull_idx(int a, int stride);
    int off, s;
    if (a % 4 != 0 || a < PB) return -1;
    off = a - PB;
    if (off >= NB*stride) return -1;
    s = (off % stride) / 4;
    if (s >= 2) return -1;
    return (off / stride) * 2 + s;
  endfunction

  function automatic logic [31:0] model_read(int a, int stride);
    int i;
    i = mux_idx(a);
    if (i >= 0) return {16'h0, m_mux[i]};
    i = pull_idx(a, stride);
    if (i >= 0) return {16'h0, (stride == 8) ? m_p8[i] : m_p16[i]};
    return 32'h0;
  endfunction

  function automatic logic [15:0] merge(logic [15:0] cur, logic [31:0] w);
    return (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic model_write(int a, logic [31:0] w);
    int i;
    i = mux_idx(a);
    if (i >= 0) m_mux[i] = merge(m_mux[i], w);
    i = pull_idx(a, 8);
    if (i >= 0) m_p8[i] = merge(m_p8[i], w);
    i = pull_idx(a, 16);
    if (i >= 0) m_p16[i] = merge(m_p16[i], w);
  endtask

  task automatic do_write(int a, logic [31:0] w);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'(a); wdata = w;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_write(a, w);
  endtask

  task automatic do_read(int a, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 12'(a);
    q_exp8.push_back(model_read(a, 8));
    q_exp16.push_back(model_read(a, 16));
    q_tag.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  always @(posedge clk) rd_pend <= req && !we;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_pend && q_tag.size() > 0) begin
      string t;
      logic [31:0] e8, e16;
      t = q_tag.pop_front(); e8 = q_exp8.pop_front(); e16 = q_exp16.pop_front();
      check({t, " rdata stride8"}, rd8, e8);
      check({t, " rdata stride16"}, rd16, e16);
    end
  end

  task automatic check_outputs(string tag);
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < 32; p++) begin
        logic [1:0] ef;
        int g;
        g  = b*32 + p;
        ef = m_mux[b*4 + p/8][(p%8)*2 +: 2];
        check({tag, " R2 func s8"},  32'(fs8[g*2 +: 2]),  32'(ef));
        check({tag, " R2 func s16"}, 32'(fs16[g*2 +: 2]), 32'(ef));
        check({tag, " R4 pull s8"},  32'(pd8[g]),  32'(m_p8[b*2 + p/16][p%16]));
        check({tag, " R4 pull s16"}, 32'(pd16[g]), 32'(m_p16[b*2 + p/16][p%16]));
      end
    end
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB*4; i++) m_mux[i] = '0;
    for (int i = 0; i < NB*2; i++) begin m_p8[i] = '0; m_p16[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3 R5: reset state
    check_outputs("R3 R5 reset");
    do_read(MB + 'h14, "R3 reset read");
    do_read(PB + 4, "R5 reset read");

    // full-mask write, readback with zero upper half (R6)
    do_write(MB + 'h18, 32'hFFFF_1BE4);
    check_outputs("R2 full write");
    do_read(MB + 'h18, "R6 readback");

    // R1: partial and empty masks
    do_write(MB + 'h18, 32'h000C_FFFF);
    check_outputs("R1 partial mask");
    do_write(MB + 'h18, 32'h0000_FFFF);
    check_outputs("R1 empty mask");
    do_read(MB + 'h18, "R1 readback");

    // R8: output changes on the accepting edge, not before
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'(MB); wdata = 32'hFFFF_0003;
    #2 check("R8 before edge", 32'(fs8[1:0]), 32'h0);
    @(posedge clk);
    #1 check("R8 after edge", 32'(fs8[1:0]), 32'h3);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_write(MB, 32'hFFFF_0003);

    // R4 R5 R9: pull words, stride dependent decode
    do_write(PB + 12, 32'h0020_0020);
    check_outputs("R4 R9 bank1 pin21");
    do_write(PB + 20, 32'hFFFF_A5A5);
    check_outputs("R4 R9 stride map");
    do_write(PB + 20, 32'h0001_0000);
    check_outputs("R5 pull re-enable");
    do_write(PB + 8, 32'hFFFF_FFFF);
    check_outputs("R9 stride16 hole");
    do_read(PB + 8,  "R9 hole read");
    do_read(PB + 12, "R9 read");
    do_read(PB + 20, "R4 read");

    // R7: unmapped offsets
    do_write(MB - 4, 32'hFFFF_FFFF);
    do_write(MB + NB*16, 32'hFFFF_FFFF);
    do_write(MB + 2, 32'hFFFF_FFFF);
    do_write(PB + NB*16, 32'hFFFF_FFFF);
    do_write('hffc, 32'hFFFF_FFFF);
    check_outputs("R7 unmapped writes");
    do_read(MB - 4, "R7 read");
    do_read(MB + 2, "R7 unaligned read");
    do_read(PB + NB*16, "R7 read");
    do_read('hffc, "R7 read");

    // R2 sweep over all mux words
    for (int i = 0; i < NB*4; i++)
      do_write(MB + 4*i, {16'hFFFF, 16'(i*4919 + 77)});
    check_outputs("R2 sweep");
    for (int i = 0; i < NB*4; i++) do_read(MB + 4*i, "R2 sweep read");

    // R4 sweep for both strides
    for (int b = 0; b < NB; b++) begin
      do_write(PB + b*8,  {16'hFFFF, 16'(b*811 + 3)});
      do_write(PB + b*16 + 4, {16'hFFFF, 16'(b*1237 + 9)});
    end
    check_outputs("R4 sweep");
    for (int a = 0; a < NB*16; a += 4) do_read(PB + a, "R4 R9 sweep read");

    // R8: idle cycles leave everything unchanged
    repeat (6) @(negedge clk);
    check_outputs("R8 idle");

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 32'(q_tag.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule